// File: doc/BRIEF.md
# Sound-Processor ALU with Status Flags

This block is the arithmetic and logic unit of a small 8-bit audio-processor core. Each clock it accepts an operation code, the accumulator A, the index register Y, a byte operand B, a 16-bit word operand W, and the incoming carry, half-carry and overflow flags. One cycle later it presents the new A and Y values and the five status flags: negative, overflow, half-carry, zero and carry.

The byte operations are add with carry, subtract with borrow, compare, AND, OR, exclusive OR and nibble swap. There are also decimal adjust after addition and after subtraction, which correct A in two steps. Y and A together form a 16-bit pair with Y as the high byte. That pair is the target of an 8x8 multiply, a pair-by-byte divide in which B acts as the divisor register, and a word add, subtract and compare against W. Instruction decode and memory access belong to the surrounding core. Any flag that an operation does not mention leaves the block equal to its input value.

Top module: `snd_alu`

## Requirements
- R1: Code 0 (add with carry): the sum is A+B+C_in. A takes the low 8 bits. C is set when the sum reaches 0x100. V is set when A and B have the same sign and the result's sign differs from B. H equals bit 4 of A^B^result.
- R2: Code 1 (subtract with borrow): the result is A−B+C_in−1. C is set when that value is zero or positive. V is set when A and B differ in sign and the result's sign differs from A. H is cleared when bit 4 of A^B^result is 1 and is set otherwise.
- R3: Code 2 (compare): A and Y are output unchanged. C is set when A ≥ B. N and Z come from the 8-bit A−B. V and H pass through unchanged.
- R4: Codes 3, 4, 5 and 6 (AND, OR, XOR of A with B, and the exchange of A's two nibbles) write A and set N and Z from the new A. C, V and H pass through unchanged.
- R5: Code 7 (decimal adjust after add): first 6 is added when A's low nibble is above 9 or H_in is 1. Then, if that value is above 0x9F or C_in is 1, 0x60 is added and C is set; otherwise C is cleared. N and Z come from the result.
- R6: Code 8 (decimal adjust after subtract): first 6 is subtracted when the low nibble is above 9 or H_in is 0. Then, if that value is above 0x9F or C_in is 0, 0x60 is subtracted and C is cleared; otherwise C is set. N and Z come from the result.
- R7: Code 9 (multiply): {Y,A} becomes A×Y. N is Y's bit 7 and Z marks Y equal to zero. C, V and H pass through.
- R8: Code 10 (divide): with a nonzero divisor B, A is the low byte of {Y,A}/B and Y is {Y,A} mod B. V is cleared and N and Z come from A.
- R9: Code 10 with B = 0 gives A = 0xFF and Y = the input A. V is cleared.
- R10: Codes 11 and 12 (word add and subtract of W to and from {Y,A}): the 16-bit result goes to {Y,A}. For add, C is set at 0x10000. For subtract, C is set when the result is non-negative. V follows the byte rules applied to bit 15. N is bit 15 and Z marks a 16-bit zero. H passes through.
- R11: Code 13 (word compare): A and Y are output unchanged. C is set when {Y,A} ≥ W. N and Z come from the 16-bit difference. V and H pass through.
- R12: Outputs are registered with one cycle of latency. A synchronous active-high reset clears A, Y and all flags to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op | input | 4 | Operation code |
| in_a | input | 8 | Accumulator A |
| in_y | input | 8 | Index register Y (high byte of the pair) |
| in_b | input | 8 | Byte operand; divisor for divide |
| in_w | input | 16 | Word operand for word operations |
| c_in | input | 1 | Incoming carry |
| h_in | input | 1 | Incoming half-carry |
| v_in | input | 1 | Incoming overflow |
| res_a | output | 8 | New A |
| res_y | output | 8 | New Y |
| flag_n | output | 1 | Negative |
| flag_v | output | 1 | Overflow |
| flag_h | output | 1 | Half-carry |
| flag_z | output | 1 | Zero |
| flag_c | output | 1 | Carry |

## Verification
Each operation code is driven with all 256 A values crossed with 32 B values that step from 0 to 255. The sweep includes both extremes, so sign changes, nibble carries and the decimal thresholds around 0x9F and low nibble 9 are all reached. The carry, half-carry and overflow inputs toggle in different patterns from the operands. That separates a flag that is computed from a flag that passes through, and it shows whether borrow and half-carry use the correct sense. The B = 0 column makes each divide sweep include a divide by zero, and Y varies so that word operations and quotient truncation see both large and small pair values.

// File: rtl/snd_alu_pkg.sv
package snd_alu_pkg;
    localparam int DW = 8;
    localparam int WW = 2 * DW;

    typedef enum logic [3:0] {
        OP_ADC  = 4'd0,
        OP_SBC  = 4'd1,
        OP_CMP  = 4'd2,
        OP_AND  = 4'd3,
        OP_OR   = 4'd4,
        OP_EOR  = 4'd5,
        OP_XCN  = 4'd6,
        OP_DAA  = 4'd7,
        OP_DAS  = 4'd8,
        OP_MUL  = 4'd9,
        OP_DIV  = 4'd10,
        OP_ADDW = 4'd11,
        OP_SUBW = 4'd12,
        OP_CMPW = 4'd13,
        OP_NOP0 = 4'd14,
        OP_NOP1 = 4'd15
    } alu_op_e;

    typedef struct packed {
        logic n;
        logic v;
        logic h;
        logic z;
        logic c;
    } alu_flags_t;

    typedef struct packed {
        logic [DW-1:0] a;
        logic [DW-1:0] y;
        alu_flags_t    f;
    } alu_out_t;

    function automatic logic is_zero8(input logic [DW-1:0] x);
        return (x == '0);
    endfunction
endpackage

// File: rtl/snd_alu_byte.sv
module snd_alu_byte
    import snd_alu_pkg::*;
(
    input  alu_op_e       op,
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    input  alu_flags_t    fin,
    output logic [DW-1:0] r,
    output alu_flags_t    fout
);
    logic [DW:0]   sum9, dif9, cmp9;
    logic [DW-1:0] hx, zsrc;

    assign sum9 = {1'b0, a} + {1'b0, b} + {{DW{1'b0}}, fin.c};
    assign dif9 = {1'b0, a} - {1'b0, b} - {{DW{1'b0}}, ~fin.c};
    assign cmp9 = {1'b0, a} - {1'b0, b};

    always_comb begin
        r    = a;
        fout = fin;
        hx   = '0;
        zsrc = a;
        case (op)
            OP_ADC: begin
                r      = sum9[DW-1:0];
                fout.c = sum9[DW];
                fout.v = ~(a[DW-1] ^ b[DW-1]) & (b[DW-1] ^ sum9[DW-1]);
                hx     = a ^ b ^ sum9[DW-1:0];
                fout.h = hx[4];
                zsrc   = r;
            end
            OP_SBC: begin
                r      = dif9[DW-1:0];
                fout.c = ~dif9[DW];
                fout.v = (a[DW-1] ^ b[DW-1]) & (a[DW-1] ^ dif9[DW-1]);
                hx     = a ^ b ^ dif9[DW-1:0];
                fout.h = ~hx[4];
                zsrc   = r;
            end
            OP_CMP: begin
                fout.c = ~cmp9[DW];
                zsrc   = cmp9[DW-1:0];
            end
            OP_AND: begin r = a & b; zsrc = r; end
            OP_OR:  begin r = a | b; zsrc = r; end
            OP_EOR: begin r = a ^ b; zsrc = r; end
            OP_XCN: begin r = {a[3:0], a[DW-1:4]}; zsrc = r; end
            default: ;
        endcase
        fout.n = zsrc[DW-1];
        fout.z = is_zero8(zsrc);
    end
endmodule

// File: rtl/snd_alu_decadj.sv
module snd_alu_decadj
    import snd_alu_pkg::*;
(
    input  logic          sub,
    input  logic [DW-1:0] a,
    input  logic          c_in,
    input  logic          h_in,
    output logic [DW-1:0] r,
    output logic          c_out
);
    localparam logic [DW-1:0] LO_FIX = 8'h06;
    localparam logic [DW-1:0] HI_FIX = 8'h60;
    localparam logic [DW-1:0] HI_LIM = 8'h9F;

    logic [DW-1:0] step1;
    logic          lo_big, lo_do, hi_do;

    always_comb begin
        lo_big = (a[3:0] > 4'd9);
        lo_do  = sub ? (lo_big | ~h_in) : (lo_big | h_in);
        if (lo_do) step1 = sub ? a - LO_FIX : a + LO_FIX;
        else       step1 = a;
        hi_do  = sub ? ((step1 > HI_LIM) | ~c_in) : ((step1 > HI_LIM) | c_in);
        if (hi_do) r = sub ? step1 - HI_FIX : step1 + HI_FIX;
        else       r = step1;
        c_out  = sub ? ~hi_do : hi_do;
    end
endmodule

// File: rtl/snd_alu_pair.sv
module snd_alu_pair
    import snd_alu_pkg::*;
(
    input  alu_op_e       op,
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] y,
    input  logic [DW-1:0] b,
    input  logic [WW-1:0] w,
    input  alu_flags_t    fin,
    output alu_out_t      out
);
    logic [WW-1:0] ya, prod, quo, wres;
    logic [WW:0]   s17, d17;
    logic [DW:0]   rem;

    assign ya   = {y, a};
    assign prod = a * y;
    assign s17  = {1'b0, ya} + {1'b0, w};
    assign d17  = {1'b0, ya} - {1'b0, w};

    always_comb begin
        rem = '0;
        quo = '0;
        for (int i = WW - 1; i >= 0; i--) begin
            rem = {rem[DW-1:0], ya[i]};
            if (rem >= {1'b0, b}) begin
                rem    = rem - {1'b0, b};
                quo[i] = 1'b1;
            end
        end
    end

    always_comb begin
        out.a = a;
        out.y = y;
        out.f = fin;
        wres  = ya;
        case (op)
            OP_MUL: begin
                {out.y, out.a} = prod;
                out.f.n = prod[WW-1];
                out.f.z = is_zero8(prod[WW-1:DW]);
            end
            OP_DIV: begin
                if (b == '0) begin
                    out.a = '1;
                    out.y = a;
                end else begin
                    out.a = quo[DW-1:0];
                    out.y = rem[DW-1:0];
                end
                out.f.v = 1'b0;
                out.f.n = out.a[DW-1];
                out.f.z = is_zero8(out.a);
            end
            OP_ADDW: begin
                wres    = s17[WW-1:0];
                {out.y, out.a} = wres;
                out.f.c = s17[WW];
                out.f.v = ~(ya[WW-1] ^ w[WW-1]) & (w[WW-1] ^ wres[WW-1]);
                out.f.n = wres[WW-1];
                out.f.z = (wres == '0);
            end
            OP_SUBW: begin
                wres    = d17[WW-1:0];
                {out.y, out.a} = wres;
                out.f.c = ~d17[WW];
                out.f.v = (ya[WW-1] ^ w[WW-1]) & (ya[WW-1] ^ wres[WW-1]);
                out.f.n = wres[WW-1];
                out.f.z = (wres == '0);
            end
            OP_CMPW: begin
                wres    = d17[WW-1:0];
                out.f.c = ~d17[WW];
                out.f.n = wres[WW-1];
                out.f.z = (wres == '0);
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/snd_alu.sv
module snd_alu
    import snd_alu_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic [3:0]    op,
    input  logic [DW-1:0] in_a,
    input  logic [DW-1:0] in_y,
    input  logic [DW-1:0] in_b,
    input  logic [WW-1:0] in_w,
    input  logic          c_in,
    input  logic          h_in,
    input  logic          v_in,
    output logic [DW-1:0] res_a,
    output logic [DW-1:0] res_y,
    output logic          flag_n,
    output logic          flag_v,
    output logic          flag_h,
    output logic          flag_z,
    output logic          flag_c
);
    alu_op_e       opc;
    alu_flags_t    fin, byte_f;
    logic [DW-1:0] byte_r, da_r;
    logic          da_c;
    alu_out_t      pair_o, nxt, q;
    logic          primed;

    assign opc = alu_op_e'(op);
    assign fin = '{n: 1'b0, v: v_in, h: h_in, z: 1'b0, c: c_in};

    snd_alu_byte u_byte (
        .op(opc), .a(in_a), .b(in_b), .fin(fin), .r(byte_r), .fout(byte_f)
    );

    snd_alu_decadj u_dec (
        .sub(opc == OP_DAS), .a(in_a), .c_in(c_in), .h_in(h_in),
        .r(da_r), .c_out(da_c)
    );

    snd_alu_pair u_pair (
        .op(opc), .a(in_a), .y(in_y), .b(in_b), .w(in_w), .fin(fin), .out(pair_o)
    );

    always_comb begin
        nxt.a = in_a;
        nxt.y = in_y;
        nxt.f = fin;
        case (opc)
            OP_ADC, OP_SBC, OP_CMP, OP_AND, OP_OR, OP_EOR, OP_XCN: begin
                nxt.a = byte_r;
                nxt.f = byte_f;
            end
            OP_DAA, OP_DAS: begin
                nxt.a   = da_r;
                nxt.f.c = da_c;
                nxt.f.n = da_r[DW-1];
                nxt.f.z = is_zero8(da_r);
            end
            OP_MUL, OP_DIV, OP_ADDW, OP_SUBW, OP_CMPW: nxt = pair_o;
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q      <= '0;
            primed <= 1'b0;
        end else begin
            q      <= nxt;
            primed <= 1'b1;
        end
    end

    assign res_a  = q.a;
    assign res_y  = q.y;
    assign flag_n = q.f.n;
    assign flag_v = q.f.v;
    assign flag_h = q.f.h;
    assign flag_z = q.f.z;
    assign flag_c = q.f.c;

    // R3: compare leaves both registers untouched
    a_r3_cmp_keeps_regs: assert property (@(posedge clk) disable iff (rst)
        (primed && $past(op) == 4'd2) |-> (res_a == $past(in_a) && res_y == $past(in_y)));

    // R4: logic and swap ops pass C, V, H through
    a_r4_logic_keeps_cvh: assert property (@(posedge clk) disable iff (rst)
        (primed && $past(op) >= 4'd3 && $past(op) <= 4'd6) |->
        (flag_c == $past(c_in) && flag_v == $past(v_in) && flag_h == $past(h_in)));

    // R8: divide always clears overflow
    a_r8_div_clears_v: assert property (@(posedge clk) disable iff (rst)
        (primed && $past(op) == 4'd10) |-> !flag_v);

    // R9: divide by zero gives a defined result
    a_r9_div_zero: assert property (@(posedge clk) disable iff (rst)
        (primed && $past(op) == 4'd10 && $past(in_b) == 8'h00) |->
        (res_a == 8'hFF && res_y == $past(in_a)));

    // R12: zero flag of byte-writing ops tracks the new A
    a_r12_zero_tracks_a: assert property (@(posedge clk) disable iff (rst)
        (primed && ($past(op) <= 4'd1 || ($past(op) >= 4'd3 && $past(op) <= 4'd8))) |->
        (flag_z == (res_a == 8'h00)));
endmodule

// File: tb/snd_alu_tb.sv
module snd_alu_tb;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 190000;

    logic        clk = 1'b0;
    logic        rst;
    logic [3:0]  op;
    logic [7:0]  in_a, in_y, in_b;
    logic [15:0] in_w;
    logic        c_in, h_in, v_in;
    logic [7:0]  res_a, res_y;
    logic        flag_n, flag_v, flag_h, flag_z, flag_c;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    snd_alu u_dut (
        .clk(clk), .rst(rst), .op(op), .in_a(in_a), .in_y(in_y), .in_b(in_b),
        .in_w(in_w), .c_in(c_in), .h_in(h_in), .v_in(v_in),
        .res_a(res_a), .res_y(res_y), .flag_n(flag_n), .flag_v(flag_v),
        .flag_h(flag_h), .flag_z(flag_z), .flag_c(flag_c)
    );

    function automatic string tag_of(input int o);
        case (o)
            0: return "R1";  1: return "R2";  2: return "R3";
            3, 4, 5, 6: return "R4";
            7: return "R5";  8: return "R6";  9: return "R7";
            10: return "R8"; 11, 12: return "R10"; 13: return "R11";
            default: return "R12";
        endcase
    endfunction

    // expected {a, y, n, v, h, z, c}
    function automatic logic [20:0] model(input int o, input int a, input int y,
                                          input int b, input int w,
                                          input int c, input int h, input int v);
        int ra = a, ry = y, n = 0, z = 0, cc = c, hh = h, vv = v, t, ya, x;
        ya = y * 256 + a;
        case (o)
            0: begin
                t = a + b + c; ra = t % 256; cc = (t >= 256);
                vv = (((a ^ b) & 8'h80) == 0) && (((b ^ ra) & 8'h80) != 0);
                hh = ((a ^ b ^ ra) & 8'h10) != 0;
            end
            1: begin
                t = a - b + c - 1; cc = (t >= 0); ra = (t + 256) % 256;
                vv = (((a ^ b) & 8'h80) != 0) && (((a ^ ra) & 8'h80) != 0);
                hh = ((a ^ b ^ ra) & 8'h10) == 0;
            end
            2: begin t = a - b; cc = (t >= 0); end
            3: ra = a & b;
            4: ra = a | b;
            5: ra = a ^ b;
            6: ra = ((a % 16) * 16) + (a / 16);
            7: begin
                t = a;
                if ((t % 16) > 9 || h != 0) t = (t + 6) % 256;
                if (t > 159 || c != 0) begin t = (t + 96) % 256; cc = 1; end else cc = 0;
                ra = t;
            end
            8: begin
                t = a;
                if ((t % 16) > 9 || h == 0) t = (t + 250) % 256;
                if (t > 159 || c == 0) begin t = (t + 160) % 256; cc = 0; end else cc = 1;
                ra = t;
            end
            9: begin t = a * y; ra = t % 256; ry = t / 256; end
            10: begin
                vv = 0;
                if (b == 0) begin ra = 255; ry = a; end
                else begin ra = (ya / b) % 256; ry = ya % b; end
            end
            11: begin
                t = ya + w; cc = (t >= 65536); t = t % 65536;
                vv = (((ya ^ w) & 16'h8000) == 0) && (((w ^ t) & 16'h8000) != 0);
                ra = t % 256; ry = t / 256;
            end
            12, 13: begin
                t = ya - w; cc = (t >= 0); t = (t + 65536) % 65536;
                if (o == 12) begin
                    vv = (((ya ^ w) & 16'h8000) != 0) && (((ya ^ t) & 16'h8000) != 0);
                    ra = t % 256; ry = t / 256;
                end
            end
            default: ;
        endcase
        if (o == 2) begin
            t = (a - b + 256) % 256; n = t >= 128; z = (t == 0);
        end else if (o == 9) begin
            n = ry >= 128; z = (ry == 0);
        end else if (o >= 11 && o <= 13) begin
            t = (o == 11) ? (ya + w) % 65536 : (ya - w + 65536) % 65536;
            n = t >= 32768; z = (t == 0);
        end else if (o <= 10) begin
            n = ra >= 128; z = (ra == 0);
        end
        return {ra[7:0], ry[7:0], n[0], vv[0], hh[0], z[0], cc[0]};
    endfunction

    task automatic check(input string tag, input logic [20:0] exp);
        logic [20:0] act;
        act = {res_a, res_y, flag_n, flag_v, flag_h, flag_z, flag_c};
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s op=%0d a=%h y=%h b=%h w=%h : got a=%h y=%h nvhzc=%b, want a=%h y=%h nvhzc=%b",
                     tag, op, in_a, in_y, in_b, in_w, act[20:13], act[12:5], act[4:0],
                     exp[20:13], exp[12:5], exp[4:0]);
        end
    endtask

    initial begin
        int cyc = 0;
        while (!done && cyc < WATCHDOG) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL R12 watchdog expired: got hung run, want completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        logic [20:0] exp;
        rst = 1'b1; op = 4'd0; in_a = 8'hA5; in_y = 8'h5A; in_b = 8'hFF;
        in_w = 16'hFFFF; c_in = 1'b1; h_in = 1'b1; v_in = 1'b1;
        repeat (3) @(posedge clk);
        #1;
        check("R12", 21'h0);          // R12: reset clears everything
        @(negedge clk);
        rst = 1'b0;
        for (int o = 0; o < 14; o++) begin
            for (int i = 0; i < 8192; i++) begin
                int a, j, b, y;
                a = i % 256;
                j = i / 256;
                b = j * 8 + (j % 8);
                y = (i * 13 + j * 101) % 256;
                @(negedge clk);
                op   = o[3:0];
                in_a = a[7:0];
                in_b = b[7:0];
                in_y = y[7:0];
                in_w = {in_b ^ 8'h3C, in_a ^ in_y};
                c_in = ((i / 2) % 2 != 0) ^ (j % 2 != 0);
                h_in = (i / 4) % 2 != 0;
                v_in = (i / 8) % 2 != 0;
                exp  = model(o, a, y, b, int'(in_w), int'(c_in), int'(h_in), int'(v_in));
                @(posedge clk);
                #1;
                if (o == 10 && b == 0) check("R9", exp);
                else check(tag_of(o), exp);
            end
        end
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule